// File: doc/BRIEF.md
# 8-bit ALU with Two-Cycle Word Arithmetic

This block is the arithmetic and logic unit of a small 8-bit RISC microcontroller core. In one cycle it turns two byte operands and an operation code into a byte result and a new set of status flags. The flags are carry C, zero Z, negative N, two's-complement overflow V, sign S and half-carry H. The datapath is combinational. The result and the new flags are valid in the same cycle in which the operands are presented. The surrounding core writes them back to the register file and the status register.

The core also has 16-bit add-immediate and subtract-immediate on a register pair. The decoder splits each of these into two consecutive cycles and tags each cycle with a phase code. The low-byte cycle is an ordinary byte add or subtract, and it sets C to the carry or borrow. In the high-byte cycle the unit takes the high register byte and folds in that carry or borrow. It then produces flags that describe the full 16-bit result.

Two flags need special handling in the high-byte cycle. Z must reflect all 16 bits, so it is combined with the Z left by the low-byte cycle. H must come out of the whole word instruction unchanged, although the low-byte add overwrites it. For this purpose the unit keeps one register that holds the incoming H during the low-byte cycle and gives it back in the high-byte cycle.

Top module: `mcu_alu`

## Requirements
- R1: Encodings and timing.
  - `op_i` codes: 0 ADD, 1 ADC, 2 SUB, 3 SBC, 4 AND, 5 OR, 6 XOR, 7 MOV.
  - `phase_i` codes: 0 byte, 1 word low byte, 2 word high byte, 3 byte.
  - Flag vectors are ordered {H,S,V,N,Z,C} at bits 5..0.
  - Result and flags are valid in the same cycle as their inputs.
- R2: ADD computes a+b. ADC computes a+b+C_in. C is the carry out of bit 7, H is the carry out of bit 3, and V is signed overflow.
- R3: SUB computes a-b. SBC computes a-b-C_in. C is the borrow out of bit 7, H is the borrow into bit 4, and V is signed overflow.
- R4: For every code except MOV, N equals result bit 7 and S equals N xor V. Outside the word high-byte cycle, Z is set exactly when the result is zero.
- R5: AND, OR and XOR clear V and pass C and H through unchanged from `flags_i`.
- R6: MOV returns b and passes all flags through unchanged.
- R7: A word low-byte cycle (phase 1) produces exactly the result and flags of the same byte operation.
- R8: In a word high-byte cycle (phase 2), code 0 or 1 returns a+C_in and code 2 or 3 returns a-C_in. Operand b is ignored. C, N, V and S then describe the full 16-bit result.
- R9: In a word high-byte cycle, Z is set only when the high result is zero and the incoming Z is set.
- R10: In a word high-byte cycle, H equals the H presented on `flags_i` during the preceding low-byte cycle.
- R11: After reset, the held H is 0. A high-byte cycle with no low-byte cycle since reset outputs H=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the held half-carry register |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 3 | Operation code (R1) |
| phase_i | input | 2 | Word phase code (R1) |
| a_i | input | DATA_W | First operand, or the register byte in word cycles |
| b_i | input | DATA_W | Second operand, or the immediate in the low-byte cycle |
| flags_i | input | 6 | Current status flags {H,S,V,N,Z,C} |
| res_o | output | DATA_W | Byte result |
| flags_o | output | 6 | Updated status flags {H,S,V,N,Z,C} |

## Verification
The bench builds the block with the default DATA_W of 8. At that width the half-carry boundary sits between bits 3 and 4, and the sign bit is bit 7. Random operands over the full byte range therefore reach every combination of C, Z, N, V, S and H, and the bench computes each one with integer arithmetic. Directed word sequences cover the 16-bit cases that random operands seldom reach:
- a zero low byte with a nonzero high byte,
- a full wrap to zero,
- signed overflow at 0x7FFF and 0x8000,
- a borrow through 0x0000,
- H restored as both 0 and 1.

// File: rtl/mcu_alu_pkg.sv
package mcu_alu_pkg;

  // Operation codes; bit 2 clear selects the adder, bit 1 selects subtract,
  // bit 0 selects use of the incoming carry.
  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_ADC = 3'd1,
    OP_SUB = 3'd2,
    OP_SBC = 3'd3,
    OP_AND = 3'd4,
    OP_OR  = 3'd5,
    OP_XOR = 3'd6,
    OP_MOV = 3'd7
  } alu_op_e;

  // Word phase codes from the decoder.
  typedef enum logic [1:0] {
    PH_BYTE = 2'd0,
    PH_WLO  = 2'd1,
    PH_WHI  = 2'd2,
    PH_RSV  = 2'd3
  } word_ph_e;

  localparam int FLAG_W = 6;

  typedef struct packed {
    logic h;
    logic s;
    logic v;
    logic n;
    logic z;
    logic c;
  } alu_flags_t;

endpackage

// File: rtl/mcu_alu_arith.sv
module mcu_alu_arith #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              cin_i,
  input  logic              sub_i,
  output logic [DATA_W-1:0] res_o,
  output logic              c_o,
  output logic              h_o,
  output logic              v_o
);

  localparam int MSB = DATA_W - 1;
  localparam int HB  = DATA_W / 2;

  logic [DATA_W:0] ext_a, ext_b, ext_c, full;
  logic [HB:0]     h_a, h_b, h_c, half;

  always_comb begin
    ext_a = {1'b0, a_i};
    ext_b = {1'b0, b_i};
    ext_c = {{DATA_W{1'b0}}, cin_i};
    h_a   = {1'b0, a_i[HB-1:0]};
    h_b   = {1'b0, b_i[HB-1:0]};
    h_c   = {{HB{1'b0}}, cin_i};
    if (sub_i) begin
      full = ext_a - ext_b - ext_c;
      half = h_a - h_b - h_c;
    end else begin
      full = ext_a + ext_b + ext_c;
      half = h_a + h_b + h_c;
    end
    res_o = full[MSB:0];
    c_o   = full[DATA_W];
    h_o   = half[HB];
    if (sub_i) begin
      v_o = (a_i[MSB] ^ b_i[MSB]) & (full[MSB] ^ a_i[MSB]);
    end else begin
      v_o = ~(a_i[MSB] ^ b_i[MSB]) & (full[MSB] ^ a_i[MSB]);
    end
  end

endmodule

// File: rtl/mcu_alu_logic.sv
module mcu_alu_logic #(
  parameter int DATA_W = 8
) (
  input  logic [1:0]        sel_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] res_o
);

  always_comb begin
    case (sel_i)
      2'b00:   res_o = a_i & b_i;
      2'b01:   res_o = a_i | b_i;
      2'b10:   res_o = a_i ^ b_i;
      default: res_o = b_i;
    endcase
  end

endmodule

// File: rtl/mcu_alu_flag_hold.sv
module mcu_alu_flag_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic cap_en_i,
  input  logic d_i,
  output logic q_o
);

  logic q_nxt;

  always_comb begin
    q_nxt = q_o;
    if (cap_en_i) begin
      q_nxt = d_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_o <= 1'b0;
    end else begin
      q_o <= q_nxt;
    end
  end

endmodule

// File: rtl/mcu_alu.sv
module mcu_alu
  import mcu_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        op_i,
  input  logic [1:0]        phase_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [5:0]        flags_i,
  output logic [DATA_W-1:0] res_o,
  output logic [5:0]        flags_o
);

  localparam int MSB = DATA_W - 1;

  alu_flags_t        fin, fout;
  logic              is_arith, is_sub, word_hi, word_lo, cin, saved_h, res_zero;
  logic [DATA_W-1:0] opnd_b, ar_res, lg_res, res;
  logic              ar_c, ar_h, ar_v;

  assign fin = alu_flags_t'(flags_i);

  // Decode: the high-byte word cycle folds in only the carry/borrow.
  always_comb begin
    is_arith = ~op_i[2];
    is_sub   = op_i[1];
    word_hi  = is_arith && (phase_i == PH_WHI);
    word_lo  = is_arith && (phase_i == PH_WLO);
    opnd_b   = word_hi ? '0 : b_i;
    cin      = (word_hi || op_i[0]) ? fin.c : 1'b0;
  end

  mcu_alu_arith #(.DATA_W(DATA_W)) u_arith (
    .a_i   (a_i),
    .b_i   (opnd_b),
    .cin_i (cin),
    .sub_i (is_sub),
    .res_o (ar_res),
    .c_o   (ar_c),
    .h_o   (ar_h),
    .v_o   (ar_v)
  );

  mcu_alu_logic #(.DATA_W(DATA_W)) u_logic (
    .sel_i (op_i[1:0]),
    .a_i   (a_i),
    .b_i   (b_i),
    .res_o (lg_res)
  );

  // Holds the pre-instruction half-carry across a word operation.
  mcu_alu_flag_hold u_hhold (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap_en_i (word_lo),
    .d_i      (fin.h),
    .q_o      (saved_h)
  );

  always_comb begin
    res      = is_arith ? ar_res : lg_res;
    res_zero = ~|res;
    fout     = fin;
    if (is_arith) begin
      fout.c = ar_c;
      fout.v = ar_v;
      fout.n = res[MSB];
      fout.s = res[MSB] ^ ar_v;
      fout.h = word_hi ? saved_h : ar_h;
      fout.z = word_hi ? (res_zero & fin.z) : res_zero;
    end else if (op_i != OP_MOV) begin
      fout.v = 1'b0;
      fout.n = res[MSB];
      fout.s = res[MSB];
      fout.z = res_zero;
    end
  end

  assign res_o   = res;
  assign flags_o = fout;

  // R10: high-byte cycle right after a low-byte cycle returns the earlier H
  a_r10_h_restore: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase_i == PH_WHI) && !op_i[2] && $past((phase_i == PH_WLO) && !op_i[2]))
      |-> (flags_o[5] == $past(flags_i[5])));

  // R9: word Z can only be set when the low-byte Z was set
  a_r9_z_word: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase_i == PH_WHI) && !op_i[2]) |-> (!flags_o[1] || flags_i[1]));

  // R4: sign relation between output flags and result
  a_r4_sign: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i != OP_MOV) |-> ((flags_o[4] == (flags_o[2] ^ flags_o[3])) && (flags_o[2] == res_o[MSB])));

  // R5: logic operations clear V and keep C and H
  a_r5_logic_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i[2] && (op_i != OP_MOV)) |-> (!flags_o[3] && (flags_o[0] == flags_i[0]) && (flags_o[5] == flags_i[5])));

  // R6: MOV passes b and the flags through
  a_r6_mov_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_MOV) |-> ((flags_o == flags_i) && (res_o == b_i)));

endmodule

// File: tb/test_mcu_alu.sv
`timescale 1ns/100ps
module test_mcu_alu;

  localparam int DW = 8;

  logic       clk, rst_n;
  logic [2:0] op;
  logic [1:0] ph;
  logic [7:0] a, b, res;
  logic [5:0] fin, fo;
  int         n_chk, n_fail;
  bit         done;

  // {op, phase, a, b, flags_in, exp_res, exp_flags}, flags {H,S,V,N,Z,C}
  localparam logic [40:0] VEC [0:11] = '{
    {3'd0, 2'd0, 8'h0F, 8'h01, 6'h00, 8'h10, 6'h20},
    {3'd0, 2'd0, 8'h80, 8'h80, 6'h00, 8'h00, 6'h1B},
    {3'd0, 2'd0, 8'h7F, 8'h01, 6'h00, 8'h80, 6'h2C},
    {3'd1, 2'd0, 8'hFF, 8'h00, 6'h01, 8'h00, 6'h23},
    {3'd2, 2'd0, 8'h10, 8'h01, 6'h00, 8'h0F, 6'h20},
    {3'd2, 2'd0, 8'h00, 8'h01, 6'h00, 8'hFF, 6'h35},
    {3'd2, 2'd0, 8'h80, 8'h01, 6'h00, 8'h7F, 6'h38},
    {3'd3, 2'd0, 8'h05, 8'h05, 6'h01, 8'hFF, 6'h35},
    {3'd4, 2'd0, 8'hF0, 8'h0F, 6'h3F, 8'h00, 6'h23},
    {3'd5, 2'd0, 8'h80, 8'h01, 6'h08, 8'h81, 6'h14},
    {3'd6, 2'd0, 8'hAA, 8'hAA, 6'h21, 8'h00, 6'h23},
    {3'd7, 2'd0, 8'h11, 8'h5A, 6'h15, 8'h5A, 6'h15}
  };

  mcu_alu #(.DATA_W(DW)) i_mcu_alu (
    .clk     (clk),
    .rst_n   (rst_n),
    .op_i    (op),
    .phase_i (ph),
    .a_i     (a),
    .b_i     (b),
    .flags_i (fin),
    .res_o   (res),
    .flags_o (fo)
  );

  initial begin
    clk = 1'b0;
    forever #2.5 clk = ~clk;
  end

  function automatic int sx8(logic [7:0] v);
    return v[7] ? int'(v) - 256 : int'(v);
  endfunction

  // Byte reference from R2-R6: returns {result, flags}
  function automatic logic [13:0] ref_byte(logic [2:0] o, logic [7:0] x, logic [7:0] y, logic [5:0] f);
    int u, hn, sv;
    logic [7:0] r;
    logic [5:0] nf;
    logic ci;
    nf = f;
    ci = o[0] ? f[0] : 1'b0;
    r  = y;
    case (o)
      3'd0, 3'd1: begin
        u = int'(x) + int'(y) + int'(ci);
        hn = int'(x[3:0]) + int'(y[3:0]) + int'(ci);
        sv = sx8(x) + sx8(y) + int'(ci);
        r = u[7:0]; nf[0] = (u > 255); nf[5] = (hn > 15); nf[3] = (sv > 127) || (sv < -128);
      end
      3'd2, 3'd3: begin
        u = int'(x) - int'(y) - int'(ci);
        hn = int'(x[3:0]) - int'(y[3:0]) - int'(ci);
        sv = sx8(x) - sx8(y) - int'(ci);
        r = u[7:0]; nf[0] = (u < 0); nf[5] = (hn < 0); nf[3] = (sv > 127) || (sv < -128);
      end
      3'd4: begin r = x & y; nf[3] = 1'b0; end
      3'd5: begin r = x | y; nf[3] = 1'b0; end
      3'd6: begin r = x ^ y; nf[3] = 1'b0; end
      default: r = y;
    endcase
    if (o != 3'd7) begin
      nf[2] = r[7];
      nf[4] = nf[2] ^ nf[3];
      nf[1] = (r == 8'h00);
    end
    return {r, nf};
  endfunction

  // Word reference from R8-R10: returns {high result, flags}
  function automatic logic [13:0] ref_word(bit sub, logic [7:0] hi, logic [7:0] lo, logic [7:0] imm, logic [5:0] f0);
    int w, u, sw, sv;
    logic [15:0] r16;
    logic [5:0] nf;
    w  = int'({hi, lo});
    sw = hi[7] ? w - 65536 : w;
    u  = sub ? w - int'(imm) : w + int'(imm);
    sv = sub ? sw - int'(imm) : sw + int'(imm);
    r16 = u[15:0];
    nf[0] = sub ? (u < 0) : (u > 65535);
    nf[1] = (r16 == 16'h0000);
    nf[2] = r16[15];
    nf[3] = (sv > 32767) || (sv < -32768);
    nf[4] = nf[2] ^ nf[3];
    nf[5] = f0[5];
    return {r16[15:8], nf};
  endfunction

  function automatic string req_of(logic [2:0] o, logic [1:0] p);
    if (p == 2'd1) return "R7";
    case (o)
      3'd0, 3'd1: return "R2";
      3'd2, 3'd3: return "R3";
      3'd7:       return "R6";
      default:    return "R5";
    endcase
  endfunction

  task automatic drive(logic [2:0] o, logic [1:0] p, logic [7:0] x, logic [7:0] y, logic [5:0] f);
    @(negedge clk);
    op = o; ph = p; a = x; b = y; fin = f;
    #1;
  endtask

  task automatic check(string req, string what, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic byte_check(logic [2:0] o, logic [1:0] p, logic [7:0] er, logic [5:0] ef);
    string rq;
    rq = req_of(o, p);
    check({rq, " R1"}, "result", int'(res), int'(er));
    check(rq, "flags", int'(fo), int'(ef));
    if (o != 3'd7) check("R4", "N/Z/S", int'(fo[4:1]), int'(ef[4:1]));
  endtask

  task automatic word_seq(bit sub, logic [7:0] hi, logic [7:0] lo, logic [7:0] imm, logic [5:0] f0);
    logic [13:0] e;
    logic [5:0]  f1;
    logic [2:0]  o;
    o = sub ? 3'd2 : 3'd0;
    drive(o, 2'd1, lo, imm, f0);
    e = ref_byte(o, lo, imm, f0);
    byte_check(o, 2'd1, e[13:6], e[5:0]);
    f1 = fo;
    drive(o, 2'd2, hi, 8'($urandom), f1);
    e = ref_word(sub, hi, lo, imm, f0);
    check("R8", "word high result", int'(res), int'(e[13:6]));
    check("R8", "word C/N/V/S", int'({fo[4:2], fo[0]}), int'({e[4:2], e[0]}));
    check("R9", "word Z", int'(fo[1]), int'(e[1]));
    check("R10", "word H", int'(fo[5]), int'(e[5]));
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [2:0]  vo;
    logic [1:0]  vp;
    logic [7:0]  va, vb, er;
    logic [5:0]  vf, ef;
    logic [13:0] e;
    n_chk = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0; op = 3'd0; ph = 2'd0; a = 8'h00; b = 8'h00; fin = 6'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R11: high-byte cycle straight after reset gives H=0 even with H in set
    drive(3'd0, 2'd2, 8'h12, 8'h77, 6'h20);
    check("R11", "H after reset", int'(fo[5]), 0);
    check("R8", "high result a+C", int'(res), 8'h12);

    // R11: reset between low and high cycles clears the held H
    drive(3'd0, 2'd1, 8'h10, 8'h01, 6'h20);
    @(negedge clk);
    rst_n = 1'b0; ph = 2'd0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    drive(3'd0, 2'd2, 8'h34, 8'h00, 6'h20);
    check("R11", "H after mid-word reset", int'(fo[5]), 0);

    // Vector table (R1 encodings, R2-R6)
    for (int i = 0; i < 12; i++) begin
      {vo, vp, va, vb, vf, er, ef} = VEC[i];
      drive(vo, vp, va, vb, vf);
      byte_check(vo, vp, er, ef);
    end

    // Random byte operations over all codes; phases 0, 1, 3 (R7)
    for (int i = 0; i < 3000; i++) begin
      vo = 3'($urandom);
      case ($urandom % 3)
        0:       vp = 2'd0;
        1:       vp = 2'd1;
        default: vp = 2'd3;
      endcase
      va = 8'($urandom); vb = 8'($urandom); vf = 6'($urandom);
      drive(vo, vp, va, vb, vf);
      e = ref_byte(vo, va, vb, vf);
      byte_check(vo, vp, e[13:6], e[5:0]);
    end

    // Directed word corners (R8 R9 R10)
    word_seq(1'b0, 8'h00, 8'hFF, 8'h01, 6'h00);
    word_seq(1'b0, 8'hFF, 8'hFF, 8'h01, 6'h20);
    word_seq(1'b0, 8'h7F, 8'hFF, 8'h01, 6'h00);
    word_seq(1'b1, 8'h00, 8'h00, 8'h01, 6'h20);
    word_seq(1'b1, 8'h80, 8'h00, 8'h01, 6'h00);
    word_seq(1'b1, 8'h00, 8'h01, 8'h01, 6'h00);
    word_seq(1'b1, 8'h01, 8'h00, 8'h00, 6'h20);
    word_seq(1'b0, 8'h01, 8'h00, 8'h00, 6'h3F);

    // Random word operations
    for (int i = 0; i < 400; i++) begin
      word_seq(1'($urandom), 8'($urandom), 8'($urandom), 8'($urandom), 6'($urandom));
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule